// File: doc/BRIEF.md
# SPI Full-Duplex Parallel I/O Expander

This block is an SPI target that gives a host one 8-bit input port and one 8-bit output port behind a single active-low chip select. When the host pulls chip select low, the block takes a snapshot of its parallel input pins. During the frame that follows, it shifts that snapshot out on MISO while it collects a new output byte from MOSI. Releasing chip select commits the collected byte to the output pins, so one transfer both reads the inputs and writes the outputs.

The serial side runs in SPI mode 0. The idle clock is low, MOSI is sampled on the rising SCLK edge, MISO changes on the falling edge, and the most significant bit comes first. The first input bit appears on MISO as soon as chip select is low. SCLK, MOSI and chip select are not clocked by the system clock. Each passes through a two-flop synchroniser, and edges are detected in the system clock domain, which must run at least four times faster than SCLK.

The bus may be shared with other targets. The output pins therefore load only from a frame that was clocked in while this block's own chip select was low and that held exactly eight bits. SCLK and MOSI activity meant for other targets is ignored. Frames that are too short or too long are discarded.

Top module: `spi_io_expander`

## Requirements
- R1: While rst_n is low, pin_out is driven to 0x00 and miso_oe is 0. After reset is released, pin_out stays 0x00 until the first valid frame.
- R2: miso_oe is 1 while chip select is held low and 0 while it is held high, after the synchroniser delay of two to three clock cycles.
- R3: pin_in is captured when chip select falls. The captured byte is presented on miso MSB first: bit 7 is valid before the first rising SCLK, and each following bit is valid after the next falling SCLK.
- R4: On each rising SCLK while chip select is low, one MOSI bit is taken, MSB first. After a frame of exactly 8 bits, pin_out equals the received byte within four clock cycles of chip select rising.
- R5: pin_out does not change while chip select is low. It holds its previous value throughout a frame.
- R6: A frame with fewer than 8 rising SCLK edges leaves pin_out unchanged. The next complete frame still commits correctly.
- R7: A frame with more than 8 rising SCLK edges leaves pin_out unchanged.
- R8: SCLK and MOSI activity while chip select is high has no effect on pin_out or on the data of the next frame.
- R9: Changes on pin_in after chip select has fallen do not alter the byte shifted out in that frame.

Top module parameters: DATA_W = 8, SYNC_STAGES = 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| pin_in | input | DATA_W | Parallel input pins |
| pin_out | output | DATA_W | Latched parallel output pins |

## Verification
The bench targets the shared-bus hazards. A design that latched the shift register on every chip-select rise, without checking the bit count, would put another target's byte, or a partial frame, onto pin_out. Frames that are one bit short or one bit long, and a burst of SCLK activity with chip select high, expose that fault. Changing pin_in in the middle of a frame catches a design that samples the pins continuously instead of once at chip-select fall. Checking pin_out before chip select is released catches a design that writes the outputs early.

// File: rtl/spi_exp_pkg.sv
// Package: shared defaults for the SPI I/O expander.
// Assumes: nothing; holds constants only.
package spi_exp_pkg;
    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Width of a counter that must reach DATA_W + 1 (the overflow mark).
    function automatic int unsigned cnt_width(input int unsigned data_w);
        return $clog2(data_w + 2);
    endfunction
endpackage

// File: rtl/spi_sync.sv
// Module: multi-bit flop-chain synchroniser.
// Assumes: each bit is an independent slow signal; the bits need no coherence
// beyond what the host's timing gives them.
module spi_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
// Module: mode-0 shift engine with bit counting.
// Assumes: inputs are already synchronised to clk; clk is at least 4x SCLK,
// so no SCLK edge is missed. Loads pin_in on the chip-select fall, shifts MISO
// on falling SCLK, collects MOSI on rising SCLK, and flags a commit on
// chip-select rise only when exactly DATA_W bits arrived.
module spi_shift_core #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] pin_in,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              commit
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DATA_W + 1);

    logic              cs_q;
    logic              sclk_q;
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic              cs_fall;
    logic              cs_rise;
    logic              sclk_rise;
    logic              sclk_fall;

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    // Decode the edges; SCLK edges count only inside this target's frame.
    always_comb begin
        cs_fall   = cs_q & ~cs_s;
        cs_rise   = ~cs_q & cs_s;
        sclk_rise = ~sclk_q & sclk_s & ~cs_s;
        sclk_fall = sclk_q & ~sclk_s & ~cs_s;
    end

    // Transmit register: snapshot on select, shift left on falling SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_sr <= '0;
        else if (cs_fall)   tx_sr <= pin_in;
        else if (sclk_fall) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end

    // Receive register: take MOSI on rising SCLK, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_sr <= '0;
        else if (sclk_rise) rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
    end

    // Bit counter: cleared on select, saturates one above a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                             bit_cnt <= '0;
        else if (cs_fall)                       bit_cnt <= '0;
        else if (sclk_rise && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

    assign tx_bit  = tx_sr[DATA_W-1];
    assign rx_byte = rx_sr;
    assign commit  = cs_rise && (bit_cnt == CNT_FULL);
endmodule

// File: rtl/spi_out_latch.sv
// Module: output pin register.
// Assumes: commit is a single-cycle pulse raised only for a complete frame.
module spi_out_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [DATA_W-1:0] pin_out
);
    // Load the received byte on commit, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      pin_out <= '0;
        else if (commit) pin_out <= rx_byte;
    end
endmodule

// File: rtl/spi_io_expander.sv
// Module: top of the SPI full-duplex I/O expander.
// Assumes: SPI mode 0, MSB first, clk at least 4x SCLK, synchronous
// active-low reset. Chains the synchroniser, the shift core and the latch.
module spi_io_expander
    import spi_exp_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out
);
    localparam int unsigned CNT_W = cnt_width(DATA_W);

    logic [2:0]        sync_q;
    logic              cs_s;
    logic              sclk_s;
    logic              mosi_s;
    logic              tx_bit;
    logic              commit;
    logic [DATA_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_cnt;

    spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({cs_n, sclk, mosi}),
        .q_sync  (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign mosi_s = sync_q[0];

    spi_shift_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .pin_in  (pin_in),
        .tx_bit  (tx_bit),
        .rx_byte (rx_byte),
        .bit_cnt (bit_cnt),
        .commit  (commit)
    );

    spi_out_latch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .rx_byte (rx_byte),
        .pin_out (pin_out)
    );

    // MISO is driven only while this target is selected.
    assign miso_oe = ~cs_s;
    assign miso    = tx_bit;
endmodule

// File: rtl/spi_io_expander_chk.sv
// Module: property checker for spi_io_expander, attached by bind.
// Assumes: two synchroniser stages, so the outputs follow cs_n within three clocks.
module spi_io_expander_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso_oe,
    input logic [DATA_W-1:0] pin_out,
    input logic [CNT_W-1:0]  bit_cnt
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && !miso_oe));

    // R2
    oe_off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_oe);

    // R2
    oe_on_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(cs_n, 2)) |-> miso_oe);

    // R5
    out_hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3)) |-> $stable(pin_out));

    // R6
    full_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> ($past(bit_cnt) == CNT_W'(DATA_W)));
endmodule

bind spi_io_expander spi_io_expander_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .miso_oe (miso_oe),
    .pin_out (pin_out),
    .bit_cnt (bit_cnt)
);

// File: tb/spi_io_expander_tb.sv
// Directed bench for spi_io_expander: one task for each scenario.
module spi_io_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_io_expander u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .pin_in  (pin_in),
        .pin_out (pin_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one frame of nbits; swaps pin_in to pin_after once the snapshot is taken.
    task automatic xfer(input logic [7:0] tx, input int nbits, input logic [7:0] pin_after,
                        input logic [7:0] out_before, output logic [7:0] rx);
        rx = 8'h00;
        cs_n = 1'b0;
        wait_clk(HALF);
        pin_in = pin_after;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? tx[7-i] : 1'b0;
            wait_clk(HALF);
            if (i < 8) rx[7-i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        chk("R2 oe while selected", {7'd0, miso_oe}, 8'h01);
        chk("R5 outputs held during frame", pin_out, out_before);
        cs_n = 1'b1;
        wait_clk(6);
        chk("R2 oe after release", {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic t_reset;
        chk("R1 pin_out at reset", pin_out, 8'h00);
        chk("R1 oe at reset", {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic t_full(input logic [7:0] pins, input logic [7:0] tx);
        logic [7:0] rx;
        logic [7:0] prev;
        prev = pin_out;
        pin_in = pins;
        wait_clk(4);
        xfer(tx, 8, pins, prev, rx);
        chk("R3 captured input shifted out", rx, pins);
        chk("R4 output byte committed", pin_out, tx);
    endtask

    task automatic t_pin_change;
        logic [7:0] rx;
        logic [7:0] prev;
        prev = pin_out;
        pin_in = 8'hF0;
        wait_clk(4);
        xfer(8'h66, 8, 8'h0F, prev, rx);
        chk("R9 snapshot kept after pin change", rx, 8'hF0);
        chk("R4 commit with pin change", pin_out, 8'h66);
    endtask

    task automatic t_short;
        logic [7:0] rx;
        logic [7:0] prev;
        prev = pin_out;
        xfer(8'hFF, 7, pin_in, prev, rx);
        chk("R6 seven-bit frame discarded", pin_out, prev);
        xfer(8'h01, 3, pin_in, prev, rx);
        chk("R6 three-bit frame discarded", pin_out, prev);
    endtask

    task automatic t_long;
        logic [7:0] rx;
        logic [7:0] prev;
        prev = pin_out;
        xfer(8'h99, 9, pin_in, prev, rx);
        chk("R7 nine-bit frame discarded", pin_out, prev);
    endtask

    task automatic t_foreign;
        logic [7:0] prev;
        prev = pin_out;
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(6);
        chk("R8 foreign traffic ignored", pin_out, prev);
        chk("R8 miso released during foreign traffic", {7'd0, miso_oe}, 8'h00);
        t_full(8'h42, 8'h81);
    endtask

    initial begin : main
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 pin_out after reset", pin_out, 8'h00);
        t_full(8'hA5, 8'h3C);
        t_full(8'h5A, 8'hC3);
        t_pin_change();
        t_short();
        t_full(8'h00, 8'hFE);
        t_long();
        t_foreign();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule